// File: doc/BRIEF.md
# Cascadable Synchronous Decade Counter

This block is one digit of a synchronous counter. It holds a four-bit binary-coded decimal value that steps 0, 1, ... 9 and then returns to 0, always on the rising clock edge. All of its bits change at the same instant, so no decoding glitches appear between states. A stage advances only when both of its enables are high. The first enable, `run_en`, gates counting alone. The second, `chain_en`, gates counting and also qualifies the carry output.

Several stages make a multi-digit counter when they share one clock and each stage's `carry_out` drives the `chain_en` of the next, more significant stage. The carry moves through plain gates inside one clock period, so no stage waits on another stage's flip-flops.

A synchronous, active-low preset copies `preset_val` into the stage and ignores both enables. An asynchronous, active-low clear overrides everything else. The modulus is a parameter that defaults to ten.

Top module: `decade_stage`

## Requirements
- R1: `value` changes on a rising edge of `clk` through counting only when `run_en` and `chain_en` are both 1. With either enable at 0 and `preset_n` at 1, `value` holds across the edge.
- R2: When counting, `value` follows the binary codes 0000, 0001, ... 1001. From 1001 the next counting edge gives 0000.
- R3: With `preset_n` at 0 on a rising edge, `value` takes `preset_val`, whatever the levels of `run_en` and `chain_en`.
- R4: A preset wins over counting. If `preset_n` is 0 while both enables are 1, `value` equals `preset_val` after the edge and is not incremented.
- R5: While `clear_n` is 0, `value` is 0000 at once, without waiting for a clock edge, regardless of `preset_n`, the enables or `clk`. It stays 0000 across edges while clear is held.
- R6: `carry_out` is 1 exactly when `value` is 1001 and `chain_en` is 1. It follows `chain_en` combinationally within the same cycle and does not depend on `run_en`.
- R7: If a code from 1010 to 1111 has been preset, the next counting edge gives 0000. Without a counting edge, the code holds.
- R8: Two stages chained through `carry_out` into `chain_en` count as a two-digit decimal counter that steps 00 through 99 and then rolls to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge except clear |
| clear_n | input | 1 | Asynchronous clear, active low |
| preset_n | input | 1 | Synchronous parallel preset, active low |
| run_en | input | 1 | Count enable that gates counting only |
| chain_en | input | 1 | Count enable that also qualifies `carry_out`; fed by the previous stage's carry |
| preset_val | input | 4 | Value copied in on a preset |
| value | output | 4 | Current BCD digit |
| carry_out | output | 1 | High when the digit is at its last value and `chain_en` is high |

## Verification
The two functions that can fall in the same cycle are counting and presetting. The bench provokes this by holding `preset_n` low while both enables are high, with a digit of 9 or an illegal code in place. It judges the result by checking that the digit equals `preset_val` rather than the incremented or wrapped value.

A second overlap is clear against preset, and against counting. Clear is asserted in the middle of a cycle while a preset and both enables are active, and the digit must read zero before the next edge and stay there.

// File: rtl/decade_pkg.sv
package decade_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2
   } stage_op_e;

endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
   import decade_pkg::*;
(
   input  logic      preset_n,
   input  logic      run_en,
   input  logic      chain_en,
   output stage_op_e op
);
   // preset outranks counting; enables only matter when no preset
   always_comb begin
      if (!preset_n)
         op = OP_LOAD;
      else if (run_en && chain_en)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end
endmodule

// File: rtl/decade_next.sv
module decade_next
   import decade_pkg::*;
#(
   parameter int MODULUS = 10,
   parameter int WIDTH   = 4
)(
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] load_val,
   input  stage_op_e        op,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] LAST     = WIDTH'(MODULUS - 1);
   localparam bit               FULL_BIN = (MODULUS == (1 << WIDTH));

   logic [WIDTH-1:0] stepped;

   generate
      if (FULL_BIN) begin : g_plain
         // modulus fills the code space: natural wrap
         assign stepped = cur + WIDTH'(1);
      end else begin : g_mod
         // last code and any unused code return to zero
         assign stepped = (cur >= LAST) ? '0 : cur + WIDTH'(1);
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_LOAD:  nxt = load_val;
         OP_COUNT: nxt = stepped;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/decade_term.sv
module decade_term #(
   parameter int MODULUS = 10,
   parameter int WIDTH   = 4
)(
   input  logic [WIDTH-1:0] cur,
   input  logic             chain_en,
   output logic             carry
);
   localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

   logic at_last;

   assign at_last = (cur == LAST);
   assign carry   = at_last & chain_en;
endmodule

// File: rtl/decade_stage.sv
module decade_stage
   import decade_pkg::*;
#(
   parameter int MODULUS = 10
)(
   input  logic                         clk,
   input  logic                         clear_n,
   input  logic                         preset_n,
   input  logic                         run_en,
   input  logic                         chain_en,
   input  logic [$clog2(MODULUS)-1:0]   preset_val,
   output logic [$clog2(MODULUS)-1:0]   value,
   output logic                         carry_out
);
   localparam int WIDTH = $clog2(MODULUS);

   generate
      if (MODULUS < 2) begin : g_bad_modulus
         $error("decade_stage: MODULUS must be at least 2");
      end
   endgenerate

   stage_op_e        op;
   logic [WIDTH-1:0] cur_q;
   logic [WIDTH-1:0] nxt;

   decade_ctrl u_ctrl (
      .preset_n (preset_n),
      .run_en   (run_en),
      .chain_en (chain_en),
      .op       (op)
   );

   decade_next #(.MODULUS(MODULUS), .WIDTH(WIDTH)) u_next (
      .cur      (cur_q),
      .load_val (preset_val),
      .op       (op),
      .nxt      (nxt)
   );

   decade_term #(.MODULUS(MODULUS), .WIDTH(WIDTH)) u_term (
      .cur      (cur_q),
      .chain_en (chain_en),
      .carry    (carry_out)
   );

   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n)
         cur_q <= '0;
      else
         cur_q <= nxt;
   end

   assign value = cur_q;
endmodule

// File: rtl/decade_stage_chk.sv
module decade_stage_chk #(
   parameter int MODULUS = 10,
   parameter int WIDTH   = 4
)(
   input logic             clk,
   input logic             clear_n,
   input logic             preset_n,
   input logic             run_en,
   input logic             chain_en,
   input logic [WIDTH-1:0] preset_val,
   input logic [WIDTH-1:0] value,
   input logic             carry_out
);
   localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

   always @(negedge clk) begin
      if (!clear_n)
         AST_CLEAR_ZERO: assert (value == '0); // R5
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clear_n)
      (preset_n && !(run_en && chain_en)) |=> $stable(value)); // R1

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!clear_n)
      (preset_n && run_en && chain_en && value < LAST) |=> value == $past(value) + WIDTH'(1)); // R2

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clear_n)
      (preset_n && run_en && chain_en && value >= LAST) |=> value == '0); // R7

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!clear_n)
      !preset_n |=> value == $past(preset_val)); // R3 R4

   AST_CARRY_AT_LAST: assert property (@(posedge clk) disable iff (!clear_n)
      carry_out |-> value == LAST); // R6

   AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clear_n)
      !chain_en |-> !carry_out); // R6
endmodule

bind decade_stage decade_stage_chk #(.MODULUS(MODULUS), .WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .clear_n    (clear_n),
   .preset_n   (preset_n),
   .run_en     (run_en),
   .chain_en   (chain_en),
   .preset_val (preset_val),
   .value      (value),
   .carry_out  (carry_out)
);

// File: tb/decade_stage_tb_top.sv
`timescale 1ns/1ps
module decade_stage_tb_top;

   typedef struct {
      int    lo;
      int    hi;
      int    clo;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       clear_n = 1'b0;
   logic       preset_n = 1'b1;
   logic       run_en = 1'b0;
   logic       chain_en = 1'b0;
   logic [3:0] d_lo = 4'd0;
   logic [3:0] d_hi = 4'd0;
   logic [3:0] q_lo, q_hi;
   logic       c_lo, c_hi;

   int checks = 0;
   int failures = 0;
   int mlo = 0;
   int mhi = 0;
   int pre_carry = 0;
   bit done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   decade_stage dut_i (
      .clk(clk), .clear_n(clear_n), .preset_n(preset_n),
      .run_en(run_en), .chain_en(chain_en), .preset_val(d_lo),
      .value(q_lo), .carry_out(c_lo)
   );

   decade_stage dut_hi_i (
      .clk(clk), .clear_n(clear_n), .preset_n(preset_n),
      .run_en(1'b1), .chain_en(c_lo), .preset_val(d_hi),
      .value(q_hi), .carry_out(c_hi)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and push the expected result
   task automatic step(input bit clr, input bit pre, input bit run, input bit chn,
                       input int dl, input int dh, input string req);
      exp_t e;
      int   lo_carry;
      @(negedge clk);
      clear_n  = clr;
      preset_n = pre;
      run_en   = run;
      chain_en = chn;
      d_lo     = 4'(dl);
      d_hi     = 4'(dh);
      lo_carry  = (mlo == 9 && chn) ? 1 : 0;
      pre_carry = lo_carry;
      if (!clr) begin
         mlo = 0; mhi = 0;
      end else if (!pre) begin
         mlo = dl; mhi = dh;
      end else begin
         if (lo_carry == 1) mhi = (mhi >= 9) ? 0 : mhi + 1;
         if (run && chn) mlo = (mlo >= 9) ? 0 : mlo + 1;
      end
      e.lo  = mlo;
      e.hi  = mhi;
      e.clo = (mlo == 9 && chn) ? 1 : 0;
      e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compare after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(int'(q_lo) == e.lo, e.req, int'(q_lo), e.lo);
            check(int'(q_hi) == e.hi, e.req, int'(q_hi), e.hi);
            check(int'(c_lo) == e.clo, "R6", int'(c_lo), e.clo);
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R5 reset state
      #1;
      check(q_lo == 4'd0, "R5", int'(q_lo), 0);
      step(0, 1, 0, 0, 0, 0, "R5");
      step(0, 0, 1, 1, 5, 5, "R5");

      // R2 R1: count through wrap
      for (int i = 0; i < 12; i++) step(1, 1, 1, 1, 0, 0, "R2");
      // R1: one enable low holds
      for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 0, "R1");
      for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, 0, "R1");

      // R3: preset with enables off
      step(1, 0, 0, 0, 7, 2, "R3");
      step(1, 1, 0, 0, 0, 0, "R3");
      // R4: preset against counting at 9
      step(1, 0, 0, 0, 9, 0, "R3");
      step(1, 0, 1, 1, 3, 4, "R4");

      // R6: carry follows chain_en within the cycle, not run_en
      step(1, 0, 0, 0, 9, 0, "R3");
      step(1, 1, 0, 0, 0, 0, "R1");
      #1 check(c_lo == 1'b0, "R6", int'(c_lo), 0);
      step(1, 1, 0, 1, 0, 0, "R1");
      #1 check(int'(c_lo) == pre_carry && c_lo == 1'b1, "R6", int'(c_lo), 1);

      // R7: illegal codes
      step(1, 0, 0, 0, 12, 0, "R3");
      step(1, 1, 0, 1, 0, 0, "R7");
      step(1, 1, 1, 1, 0, 0, "R7");
      step(1, 0, 1, 1, 15, 0, "R4");
      step(1, 1, 1, 1, 0, 0, "R7");

      // R5: asynchronous clear mid cycle against preset and count
      step(1, 0, 1, 1, 6, 6, "R3");
      @(posedge clk);
      #1.2;
      clear_n = 1'b0;
      #0.4;
      check(q_lo == 4'd0, "R5", int'(q_lo), 0);
      check(q_hi == 4'd0, "R5", int'(q_hi), 0);
      mlo = 0; mhi = 0;
      step(0, 0, 1, 1, 4, 4, "R5");

      // R8: cascade 00 .. 99 .. 00
      step(1, 1, 0, 0, 0, 0, "R8");
      for (int i = 0; i < 105; i++) step(1, 1, 1, 1, 0, 0, "R8");
      step(1, 0, 0, 0, 8, 9, "R3");
      for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, "R8");

      step(1, 1, 0, 0, 0, 0, "R1");
      while (sb.size() > 0) @(posedge clk);
      #2;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule